// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block sits in front of the execution sequencer of a small 8-bit CPU core. One clock equals one bus cycle. It watches an active-low, level-sensitive maskable request (`irq_n`) and an active-low, edge-triggered non-maskable request (`nmi_n`). At every opcode-fetch (sync) cycle it decides between two outcomes. Either the fetched instruction runs, or the sequencer starts an interrupt entry. When an entry starts, the block also says which kind it is. The sequencer owns the bus cycles, the stack pushes and the vector fetch. This block only decides, then holds the chosen kind steady until the next sync cycle, so the vector cannot change part-way through an entry.

A falling edge on `nmi_n` is caught by a toggle flop clocked by the pin itself. A low pulse of any width is therefore recorded, even one that ends inside a single cycle. The edge then passes a short synchronising chain into a pending bit. That bit stays set until the sequencer acknowledges a non-maskable entry. Both requests need a fixed lead of `LEAD` cycles (default 2) before a sync cycle can honour them. A request that shows up during a running entry, or during a break sequence, waits for the next sync cycle.

The kind of sequence in progress lives in a four-state machine that changes only in sync cycles:
- `SEQ_NONE`: ordinary instructions are running.
- `SEQ_MASK`: a maskable entry is running.
- `SEQ_NMI`: a non-maskable entry is running.
- `SEQ_BRK`: a break instruction is running.

The transitions, all taken in a sync cycle, are:
- Any state goes to `SEQ_NMI` when a non-maskable request is pending and acknowledged.
- Any state goes to `SEQ_MASK` when only the maskable request is eligible and acknowledged.
- Any state goes to `SEQ_BRK` when nothing is taken and the fetched opcode is a break.
- Any state goes to `SEQ_NONE` otherwise.

Top module: `irq_arbiter`

## Requirements
- R1: When `irq_n` is first sampled low in cycle k, a sync cycle at k+1 does not take an interrupt. A sync cycle at k+2 or later takes one if `irq_n` was low in both of the two preceding cycles.
- R2: A falling edge on `nmi_n` is captured whatever the width of the low pulse, including a pulse that rises again within the same cycle.
- R3: A non-maskable edge in cycle k is not honoured by a sync cycle at k+1. It is honoured by the first sync cycle at k+2 or later.
- R4: Between two sync cycles, `is_nmi` and `is_brk` hold the values decided at the earlier sync cycle. A request arriving in that interval is decided at the next sync cycle, and `entry_ack` is only raised together with `take_interrupt`.
- R5: A pending non-maskable request stays pending until a sync cycle with `entry_ack` takes it. A new edge in or after that sync cycle makes it pending again.
- R6: A sync cycle that fetches a break (`brk_op`=1) with no request eligible sets `is_brk`=1 and `take_interrupt`=0. A maskable request that goes low during that cycle is honoured only at a later sync cycle.
- R7: When the maskable request is eligible at a sync cycle with `brk_op`=1, that cycle is taken as a maskable entry: `take_interrupt`=1, `is_brk`=0, `is_nmi`=0.
- R8: While `int_disable`=1 the maskable request is not taken. The non-maskable request ignores `int_disable`.
- R9: When both requests are eligible at one sync cycle, `is_nmi`=1. The maskable request is taken at a later sync cycle if `irq_n` is still low.
- R10: During reset and right after it, `take_interrupt`, `is_nmi` and `is_brk` are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge sensitive |
| int_disable | input | 1 | Interrupt-disable flag from the status register |
| sync | input | 1 | High in opcode-fetch cycles |
| brk_op | input | 1 | Fetched opcode is a break (valid with `sync`) |
| entry_ack | input | 1 | Sequencer accepts the entry in this sync cycle |
| take_interrupt | output | 1 | Replace this fetch by an interrupt entry |
| is_nmi | output | 1 | Entry uses the non-maskable vector (held until next sync) |
| is_brk | output | 1 | A break sequence is running (held until next sync) |

## Verification
The three outputs are combinational in the sync cycle, with no added delay. A request reaches them only after its `LEAD`-cycle history has filled: a level sampled low in cycle k, or an edge in cycle k, first counts in cycle k+2. The bench drives inputs just after the falling clock edge and fires non-maskable pulses inside the low half-cycle. It samples the outputs one nanosecond before the rising edge and compares them with a model that shifts its own two-cycle request history at each step. Directed cases then probe the sync cycles at exactly k+1 and k+2. They also cover the held values inside a sequence and the sync cycle right after a non-maskable entry, where a re-armed request must not yet be visible.

// File: rtl/irq_arbiter_pkg.sv
package irq_arbiter_pkg;

    typedef enum logic [1:0] {
        SEQ_NONE = 2'd0,
        SEQ_MASK = 2'd1,
        SEQ_NMI  = 2'd2,
        SEQ_BRK  = 2'd3
    } seq_kind_e;

endpackage

// File: rtl/irq_level_sampler.sv
module irq_level_sampler #(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    output logic eligible
);

    logic [LEAD-1:0] hist_q;

    generate
        if (LEAD < 2) begin : g_bad_lead
            initial $fatal(1, "LEAD must be at least 2");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[LEAD-2:0], ~irq_n};
        end
    end

    // request must have been low in each of the last LEAD cycles
    assign eligible = &hist_q;

endmodule

// File: rtl/nmi_edge_capture.sv
module nmi_edge_capture #(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clear_i,
    output logic pending
);

    logic            tog_q;
    logic [LEAD-1:0] chain_q;
    logic            edge_seen;
    logic            pend_q;

    // a falling edge of any width flips the toggle
    always_ff @(negedge nmi_n or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LEAD-2:0], tog_q};
        end
    end

    assign edge_seen = chain_q[LEAD-2] ^ chain_q[LEAD-1];

    // set wins over clear so a fresh edge is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= edge_seen | (pend_q & ~clear_i);
        end
    end

    assign pending = pend_q;

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !clear_i |=> pend_q); // R5

endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
    import irq_arbiter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    input  logic brk_op,
    input  logic int_disable,
    input  logic irq_elig,
    input  logic nmi_pend,
    input  logic entry_ack,
    output logic take_interrupt,
    output logic is_nmi,
    output logic is_brk,
    output logic nmi_clear
);

    seq_kind_e state_q;
    seq_kind_e state_d;
    logic      irq_ok;
    logic      want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_ok         = irq_elig & ~int_disable;
        want           = nmi_pend | irq_ok;
        take_interrupt = sync & want;
        nmi_clear      = sync & entry_ack & nmi_pend;
        state_d        = state_q;
        is_nmi         = 1'b0;
        is_brk         = 1'b0;
        if (sync) begin
            is_nmi = nmi_pend;
            is_brk = brk_op & ~want;
            if (want && entry_ack) begin
                state_d = nmi_pend ? SEQ_NMI : SEQ_MASK;
            end else if (brk_op && !want) begin
                state_d = SEQ_BRK;
            end else begin
                state_d = SEQ_NONE;
            end
        end else begin
            unique case (state_q)
                SEQ_NONE: begin is_nmi = 1'b0; is_brk = 1'b0; end
                SEQ_MASK: begin is_nmi = 1'b0; is_brk = 1'b0; end
                SEQ_NMI:  begin is_nmi = 1'b1; is_brk = 1'b0; end
                SEQ_BRK:  begin is_nmi = 1'b0; is_brk = 1'b1; end
            endcase
        end
    end

    AST_NMI_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        sync && nmi_pend && irq_elig |-> is_nmi && take_interrupt); // R9

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic int_disable,
    input  logic sync,
    input  logic brk_op,
    input  logic entry_ack,
    output logic take_interrupt,
    output logic is_nmi,
    output logic is_brk
);

    logic irq_elig;
    logic nmi_pend;
    logic nmi_clear;

    irq_level_sampler #(.LEAD(LEAD)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .eligible (irq_elig)
    );

    nmi_edge_capture #(.LEAD(LEAD)) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .clear_i (nmi_clear),
        .pending (nmi_pend)
    );

    entry_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync           (sync),
        .brk_op         (brk_op),
        .int_disable    (int_disable),
        .irq_elig       (irq_elig),
        .nmi_pend       (nmi_pend),
        .entry_ack      (entry_ack),
        .take_interrupt (take_interrupt),
        .is_nmi         (is_nmi),
        .is_brk         (is_brk),
        .nmi_clear      (nmi_clear)
    );

    AST_IRQ_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        take_interrupt && !is_nmi |-> !$past(irq_n) && !$past(irq_n, 2)); // R1

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        take_interrupt && !is_nmi |-> !int_disable); // R8

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync && !$past(sync) |-> is_nmi == $past(is_nmi) && is_brk == $past(is_brk)); // R4

    AST_ACK_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ack |-> take_interrupt); // R4

    AST_BRK_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        take_interrupt |-> !is_brk); // R7

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_n = 1'b1;
    logic nmi_n = 1'b1;
    logic int_disable = 1'b0;
    logic sync = 1'b0;
    logic brk_op = 1'b0;
    logic entry_ack = 1'b0;
    logic take_interrupt;
    logic is_nmi;
    logic is_brk;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the requirements
    bit m_h1, m_h2, m_e1, m_pend;
    int m_st;  // 0 none, 1 maskable, 2 non-maskable, 3 break
    bit obs_take, obs_nmi, obs_brk;

    always #4 clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .int_disable(int_disable), .sync(sync), .brk_op(brk_op),
        .entry_ack(entry_ack), .take_interrupt(take_interrupt),
        .is_nmi(is_nmi), .is_brk(is_brk)
    );

    function automatic bit f_want(input bit idis);
        return m_pend | (m_h1 & m_h2 & ~idis);
    endfunction

    function automatic bit f_take(input bit s, input bit idis);
        return s & f_want(idis);
    endfunction

    function automatic bit f_nmi(input bit s);
        return s ? m_pend : (m_st == 2);
    endfunction

    function automatic bit f_brk(input bit s, input bit b, input bit idis);
        return s ? (b & ~f_want(idis)) : (m_st == 3);
    endfunction

    task automatic chk(input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    // nmode: 0 none, 1 short pulse, 2 fall and stay low, 3 rise
    task automatic step(input bit s, input bit b, input bit idis, input bit ilow,
                        input int nmode, input string tag);
        bit edge_now, e_take, e_nmi, e_brk, clr;
        @(negedge clk);
        sync = s; brk_op = b; int_disable = idis; irq_n = ~ilow; entry_ack = 1'b0;
        edge_now = 1'b0;
        case (nmode)
            1: begin #1 nmi_n = 1'b0; #1 nmi_n = 1'b1; edge_now = 1'b1; end
            2: begin #1 edge_now = nmi_n; nmi_n = 1'b0; #1; end
            3: begin #1 nmi_n = 1'b1; #1; end
            default: #2;
        endcase
        #1;
        e_take = f_take(s, idis);
        e_nmi  = f_nmi(s);
        e_brk  = f_brk(s, b, idis);
        chk(take_interrupt, e_take, {tag, " take_interrupt"});
        chk(is_nmi, e_nmi, {tag, " is_nmi"});
        chk(is_brk, e_brk, {tag, " is_brk"});
        obs_take = take_interrupt; obs_nmi = is_nmi; obs_brk = is_brk;
        entry_ack = take_interrupt;
        clr = s & e_take & m_pend;
        if (s) m_st = e_take ? (m_pend ? 2 : 1) : (b ? 3 : 0);
        m_pend = (m_pend & ~clr) | m_e1;
        m_e1 = edge_now;
        m_h2 = m_h1;
        m_h1 = ilow;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "idle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_dummy;
        bit r_il, r_id;
        seed_dummy = $urandom(32'd2024);
        m_h1 = 0; m_h2 = 0; m_e1 = 0; m_pend = 0; m_st = 0;
        // R10 reset state with requests asserted
        sync = 1'b1; irq_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(take_interrupt, 1'b0, "R10 reset take");
        chk(is_nmi, 1'b0, "R10 reset is_nmi");
        chk(is_brk, 1'b0, "R10 reset is_brk");
        @(negedge clk);
        sync = 1'b0; irq_n = 1'b1;
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, "R10 after reset");
        chk(obs_take, 1'b0, "R10 nothing pending");

        // R1 latency of the maskable level
        idle(2);
        step(0, 0, 0, 1, 0, "R1 low k");
        step(1, 0, 0, 1, 0, "R1 sync k+1");
        chk(obs_take, 1'b0, "R1 too early");
        step(1, 0, 0, 1, 0, "R1 sync k+2");
        chk(obs_take, 1'b1, "R1 taken");
        chk(obs_nmi, 1'b0, "R1 maskable vector");
        idle(3);

        // R2 R3 short pulse and its latency
        step(0, 0, 0, 0, 1, "R2 pulse k");
        step(1, 0, 0, 0, 0, "R3 sync k+1");
        chk(obs_take, 1'b0, "R3 too early");
        step(1, 0, 0, 0, 0, "R3 sync k+2");
        chk(obs_take, 1'b1, "R2 short pulse captured");
        chk(obs_nmi, 1'b1, "R3 nmi vector");
        step(0, 0, 0, 0, 0, "R4 hold");
        chk(obs_nmi, 1'b1, "R4 nmi held");
        step(1, 0, 0, 0, 0, "R5 cleared");
        chk(obs_take, 1'b0, "R5 cleared after service");
        idle(2);

        // R2 long low level gives one request only
        step(0, 0, 0, 0, 2, "R2 fall");
        step(0, 0, 0, 0, 0, "R2 low");
        step(1, 0, 0, 0, 0, "R2 sync");
        chk(obs_nmi, 1'b1, "R2 wide low captured");
        step(0, 0, 0, 0, 3, "R2 rise");
        step(1, 0, 0, 0, 0, "R2 once");
        chk(obs_take, 1'b0, "R2 single entry per edge");
        idle(2);

        // R4 edge during maskable entry is deferred
        step(0, 0, 0, 1, 0, "R4 low");
        step(0, 0, 0, 1, 0, "R4 low");
        step(1, 0, 0, 1, 0, "R4 sync");
        chk(obs_take, 1'b1, "R4 maskable taken");
        step(0, 0, 0, 0, 1, "R4 pulse in seq");
        step(0, 0, 0, 0, 0, "R4 seq");
        step(0, 0, 0, 0, 0, "R4 seq");
        chk(obs_nmi, 1'b0, "R4 vector unchanged");
        step(1, 0, 0, 0, 0, "R4 next sync");
        chk(obs_take & obs_nmi, 1'b1, "R4 deferred nmi");
        idle(3);

        // R5 edge in the servicing sync cycle re-arms
        step(0, 0, 0, 0, 1, "R5 pulse");
        step(0, 0, 0, 0, 0, "R5 wait");
        step(1, 0, 0, 0, 1, "R5 sync+pulse");
        chk(obs_nmi, 1'b1, "R5 first entry");
        step(1, 0, 0, 0, 0, "R5 sync k+3");
        chk(obs_take, 1'b0, "R5 not yet visible");
        step(1, 0, 0, 0, 0, "R5 sync k+4");
        chk(obs_take & obs_nmi, 1'b1, "R5 re-armed entry");
        idle(3);

        // R6 request falls during break fetch
        step(1, 1, 0, 1, 0, "R6 brk sync");
        chk(obs_brk, 1'b1, "R6 break runs");
        chk(obs_take, 1'b0, "R6 not taken");
        step(0, 0, 0, 1, 0, "R6 seq");
        chk(obs_brk, 1'b1, "R6 break held");
        step(1, 0, 0, 1, 0, "R6 later sync");
        chk(obs_take, 1'b1, "R6 maskable later");
        idle(3);

        // R7 eligible request beats break
        step(0, 0, 0, 1, 0, "R7 low");
        step(0, 0, 0, 1, 0, "R7 low");
        step(1, 1, 0, 1, 0, "R7 brk sync");
        chk(obs_take, 1'b1, "R7 taken");
        chk(obs_brk, 1'b0, "R7 no break");
        idle(3);

        // R8 disable flag
        step(0, 0, 1, 1, 0, "R8 low");
        step(0, 0, 1, 1, 0, "R8 low");
        step(1, 0, 1, 1, 0, "R8 sync masked");
        chk(obs_take, 1'b0, "R8 masked");
        step(0, 0, 1, 0, 1, "R8 pulse");
        step(0, 0, 1, 0, 0, "R8 wait");
        step(1, 0, 1, 0, 0, "R8 nmi unmasked");
        chk(obs_take & obs_nmi, 1'b1, "R8 nmi ignores flag");
        idle(3);

        // R9 priority
        step(0, 0, 0, 1, 1, "R9 both");
        step(0, 0, 0, 1, 0, "R9 low");
        step(1, 0, 0, 1, 0, "R9 sync");
        chk(obs_nmi, 1'b1, "R9 nmi wins");
        step(0, 0, 0, 1, 0, "R9 seq");
        step(1, 0, 0, 1, 0, "R9 next sync");
        chk(obs_take, 1'b1, "R9 maskable follows");
        chk(obs_nmi, 1'b0, "R9 maskable vector");
        idle(3);

        // random mix: R1 R3 R4 R8 R9
        r_il = 0; r_id = 0;
        for (int i = 0; i < 4000; i++) begin
            bit rs, rb;
            int nm;
            if ($urandom_range(7) == 0) r_il = ~r_il;
            if ($urandom_range(19) == 0) r_id = ~r_id;
            rs = ($urandom_range(2) == 0);
            rb = rs && ($urandom_range(5) == 0);
            nm = ($urandom_range(11) == 0) ? 1 : 0;
            step(rs, rb, r_id, r_il, nm, "R1 R3 R4 R9 random");
        end
        finish_run();
    end

endmodule